// File: doc/BRIEF.md
# Scalar ALU with Condition Flag

This block is the execute stage of a scalar unit in a GPU-style core. Each accepted operation takes a 5-bit opcode and two 64-bit source operands and computes one destination value. It also updates a single condition bit. The operations are: bitwise logic in eight flavours, each with a 32-bit and a 64-bit form; a 32-bit and a 64-bit left shift; signed and unsigned 32-bit minimum and maximum; and a 32-bit signed add that reports overflow.

The caller presents the operation with `in_valid` high for one cycle. The destination value, the condition bit and a result strobe appear registered on the next clock. Each operation family has its own rule for the condition bit:
- Logic and shift operations report whether the written value is nonzero.
- Min and max report the comparison outcome.
- Add reports signed overflow.

An opcode outside the assigned set writes zero, keeps the condition bit and raises a flag for that result.

Top module: `scalar_alu`

## Requirements
- R1: Outputs are registered: after a cycle with `in_valid` high, `res_valid` is high in the next cycle, and `res_out`, `cond_out` and `bad_op` carry that operation's outcome.
- R2: A synchronous active-high `rst` clears `cond_out`, `res_valid`, `bad_op` and `res_out`.
- R3: Logic opcodes, even for the 32-bit form and odd for the 64-bit form: 14/15 AND, 16/17 OR, 18/19 XOR, 20/21 AND with inverted `src_b`, 22/23 OR with inverted `src_b`, 24/25 NAND, 26/27 NOR, 28/29 XNOR.
- R4: For opcodes 14 to 31, `cond_out` is 1 exactly when the written `res_out` is nonzero.
- R5: Every 32-bit operation uses only bits [31:0] of the sources and drives `res_out[63:32]` to zero. The 32-bit operations are opcodes 2, 6 to 9, and the even opcodes from 14 to 30.
- R6: Opcode 30 shifts `src_a[31:0]` left by `src_b[4:0]` and keeps 32 bits. Opcode 31 shifts the 64-bit `src_a` left by `src_b[5:0]`.
- R7: Opcodes 6 and 8 are signed min and max; opcodes 7 and 9 are unsigned min and max. Each writes the selected operand. `cond_out` is set to (a < b) for min and to (a > b) for max, so equal operands give 0.
- R8: Opcode 2 writes the low 32 bits of a + b. `cond_out` is 1 when the exact sum lies outside the signed 32-bit range.
- R9: Any other opcode writes zero to `res_out`, leaves `cond_out` unchanged and sets `bad_op` for that result.
- R10: While `in_valid` is low, `res_valid` and `bad_op` go low in the next cycle, and `cond_out` and `res_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 5 | Operation select |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| res_out | output | 64 | Registered destination value |
| cond_out | output | 1 | Registered condition bit |
| res_valid | output | 1 | High one cycle after an accepted operation |
| bad_op | output | 1 | Result came from an unassigned opcode |

## Verification
Some rules hold on every cycle, and the assertions check them continuously:
- the one-cycle strobe timing and the idle hold;
- the nonzero rule for logic and shift results;
- the zeroed upper half of 32-bit results;
- the min/max result being one of the two operands;
- the add overflow relation;
- the zero result and kept flag for unassigned opcodes.

Other behaviour can only be shown by the bench's directed scenarios with computed expected values:
- that each opcode selects the right logic function;
- that the shift counts are masked to the correct width;
- that signedness changes the min/max choice;
- the exact overflow boundaries.

// File: rtl/salu_pkg.sv
package salu_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OPC_ADD_S   = 5'd2;
    localparam logic [OPC_W-1:0] OPC_MIN_S   = 5'd6;
    localparam logic [OPC_W-1:0] OPC_MIN_U   = 5'd7;
    localparam logic [OPC_W-1:0] OPC_MAX_S   = 5'd8;
    localparam logic [OPC_W-1:0] OPC_MAX_U   = 5'd9;
    localparam logic [OPC_W-1:0] OPC_LOGIC_LO = 5'd14;
    localparam logic [OPC_W-1:0] OPC_LOGIC_HI = 5'd29;
    localparam logic [OPC_W-1:0] OPC_SHL_N   = 5'd30;
    localparam logic [OPC_W-1:0] OPC_SHL_W   = 5'd31;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_ADD,
        CLS_MIN,
        CLS_MAX
    } op_class_e;

    // order follows the opcode pairs starting at OPC_LOGIC_LO
    typedef enum logic [2:0] {
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_ANDN,
        FN_ORN,
        FN_NAND,
        FN_NOR,
        FN_XNOR
    } logic_fn_e;

    typedef struct packed {
        op_class_e cls;
        logic_fn_e fn;
        logic      wide;
        logic      signed_cmp;
        logic      legal;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [OPC_W-1:0] op);
        op_ctrl_t        c;
        logic [OPC_W-1:0] rel;
        c.cls        = CLS_NONE;
        c.fn         = FN_AND;
        c.wide       = 1'b0;
        c.signed_cmp = 1'b0;
        c.legal      = 1'b1;
        rel          = op - OPC_LOGIC_LO;
        if (op == OPC_ADD_S) begin
            c.cls = CLS_ADD;
        end else if (op == OPC_MIN_S || op == OPC_MIN_U) begin
            c.cls        = CLS_MIN;
            c.signed_cmp = (op == OPC_MIN_S);
        end else if (op == OPC_MAX_S || op == OPC_MAX_U) begin
            c.cls        = CLS_MAX;
            c.signed_cmp = (op == OPC_MAX_S);
        end else if (op >= OPC_LOGIC_LO && op <= OPC_LOGIC_HI) begin
            c.cls  = CLS_LOGIC;
            c.fn   = logic_fn_e'(rel[3:1]);
            c.wide = op[0];
        end else if (op == OPC_SHL_N || op == OPC_SHL_W) begin
            c.cls  = CLS_SHIFT;
            c.wide = op[0];
        end else begin
            c.legal = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/salu_decode.sv
module salu_decode
    import salu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_ctrl_t         ctrl
);
    always_comb begin
        ctrl = decode_op(opcode);
    end
endmodule

// File: rtl/salu_bitops.sv
module salu_bitops
    import salu_pkg::*;
#(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [WIDE_W-1:0] a,
    input  logic [WIDE_W-1:0] b,
    input  logic_fn_e         fn,
    input  logic              is_shift,
    input  logic              wide,
    output logic [WIDE_W-1:0] result
);
    localparam int SHW_W = $clog2(WIDE_W);
    localparam int SHN_W = $clog2(NARROW_W);
    localparam int UP_W  = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] logic_val;
    logic [WIDE_W-1:0] shift_src;
    logic [SHW_W-1:0]  shift_amt;
    logic [WIDE_W-1:0] raw;

    always_comb begin
        unique case (fn)
            FN_AND:  logic_val = a & b;
            FN_OR:   logic_val = a | b;
            FN_XOR:  logic_val = a ^ b;
            FN_ANDN: logic_val = a & ~b;
            FN_ORN:  logic_val = a | ~b;
            FN_NAND: logic_val = ~(a & b);
            FN_NOR:  logic_val = ~(a | b);
            default: logic_val = ~(a ^ b);
        endcase
    end

    generate
        if (SHW_W > SHN_W) begin : g_amt_ext
            always_comb begin
                shift_amt = wide ? b[SHW_W-1:0]
                                 : {{(SHW_W-SHN_W){1'b0}}, b[SHN_W-1:0]};
            end
        end else begin : g_amt_same
            always_comb shift_amt = b[SHW_W-1:0];
        end
    endgenerate

    always_comb begin
        shift_src = wide ? a : {{UP_W{1'b0}}, a[NARROW_W-1:0]};
        raw       = is_shift ? (shift_src << shift_amt) : logic_val;
        result    = wide ? raw : {{UP_W{1'b0}}, raw[NARROW_W-1:0]};
    end
endmodule

// File: rtl/salu_arith.sv
module salu_arith
    import salu_pkg::*;
#(
    parameter int NARROW_W = 32
) (
    input  logic [NARROW_W-1:0] a,
    input  logic [NARROW_W-1:0] b,
    input  op_class_e           cls,
    input  logic                signed_cmp,
    output logic [NARROW_W-1:0] result,
    output logic                flag
);
    logic [NARROW_W:0] sum;
    logic              ovf;
    logic              lt;
    logic              gt;

    always_comb begin
        sum = {a[NARROW_W-1], a} + {b[NARROW_W-1], b};
        ovf = sum[NARROW_W] ^ sum[NARROW_W-1];
        if (signed_cmp) begin
            lt = $signed(a) < $signed(b);
            gt = $signed(a) > $signed(b);
        end else begin
            lt = a < b;
            gt = a > b;
        end
        unique case (cls)
            CLS_MIN: begin
                result = lt ? a : b;
                flag   = lt;
            end
            CLS_MAX: begin
                result = gt ? a : b;
                flag   = gt;
            end
            default: begin
                result = sum[NARROW_W-1:0];
                flag   = ovf;
            end
        endcase
    end
endmodule

// File: rtl/scalar_alu.sv
module scalar_alu
    import salu_pkg::*;
#(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [4:0]        opcode,
    input  logic [WIDE_W-1:0] src_a,
    input  logic [WIDE_W-1:0] src_b,
    output logic [WIDE_W-1:0] res_out,
    output logic              cond_out,
    output logic              res_valid,
    output logic              bad_op
);
    localparam int UP_W = WIDE_W - NARROW_W;

    op_ctrl_t            ctrl;
    logic [WIDE_W-1:0]   bit_res;
    logic [NARROW_W-1:0] ar_res;
    logic                ar_flag;
    logic [WIDE_W-1:0]   nxt_res;
    logic                nxt_cond;

    salu_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    salu_bitops #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_bit (
        .a        (src_a),
        .b        (src_b),
        .fn       (ctrl.fn),
        .is_shift (ctrl.cls == CLS_SHIFT),
        .wide     (ctrl.wide),
        .result   (bit_res)
    );

    salu_arith #(.NARROW_W(NARROW_W)) u_ar (
        .a          (src_a[NARROW_W-1:0]),
        .b          (src_b[NARROW_W-1:0]),
        .cls        (ctrl.cls),
        .signed_cmp (ctrl.signed_cmp),
        .result     (ar_res),
        .flag       (ar_flag)
    );

    always_comb begin
        unique case (ctrl.cls)
            CLS_LOGIC, CLS_SHIFT: begin
                nxt_res  = bit_res;
                nxt_cond = |bit_res;
            end
            CLS_ADD, CLS_MIN, CLS_MAX: begin
                nxt_res  = {{UP_W{1'b0}}, ar_res};
                nxt_cond = ar_flag;
            end
            default: begin
                nxt_res  = '0;
                nxt_cond = cond_out;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out   <= '0;
            cond_out  <= 1'b0;
            res_valid <= 1'b0;
            bad_op    <= 1'b0;
        end else begin
            res_valid <= in_valid;
            bad_op    <= in_valid & ~ctrl.legal;
            if (in_valid) begin
                res_out  <= nxt_res;
                cond_out <= nxt_cond;
            end
        end
    end
endmodule

// File: rtl/salu_checker.sv
module salu_checker #(
    parameter int WIDE_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [4:0]        opcode,
    input logic [WIDE_W-1:0] src_a,
    input logic [WIDE_W-1:0] src_b,
    input logic [WIDE_W-1:0] res_out,
    input logic              cond_out,
    input logic              res_valid,
    input logic              bad_op
);
    a_r1_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid && !bad_op && $stable(cond_out) && $stable(res_out));

    a_r4_nonzero_flag: assert property (@(posedge clk) disable iff (rst)
        in_valid && opcode >= 5'd14 |=> cond_out == (res_out != '0));

    a_r5_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        in_valid && opcode >= 5'd14 && !opcode[0] |=> res_out[WIDE_W-1:32] == '0);

    a_r7_pick_operand: assert property (@(posedge clk) disable iff (rst)
        in_valid && opcode >= 5'd6 && opcode <= 5'd9 |=>
        (res_out[31:0] == $past(src_a[31:0]) || res_out[31:0] == $past(src_b[31:0]))
        && res_out[WIDE_W-1:32] == '0);

    a_r8_add_overflow: assert property (@(posedge clk) disable iff (rst)
        in_valid && opcode == 5'd2 |=>
        cond_out == ($past(src_a[31]) == $past(src_b[31]) && res_out[31] != $past(src_a[31])));

    a_r9_bad_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> res_out == '0 && cond_out == $past(cond_out) && res_valid);
endmodule

bind scalar_alu salu_checker #(.WIDE_W(WIDE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .src_a     (src_a),
    .src_b     (src_b),
    .res_out   (res_out),
    .cond_out  (cond_out),
    .res_valid (res_valid),
    .bad_op    (bad_op)
);

// File: tb/scalar_alu_test.sv
`timescale 1ns/1ps
module scalar_alu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  opcode = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] res_out;
    logic        cond_out;
    logic        res_valid;
    logic        bad_op;

    int n_tests = 0;
    int n_fail  = 0;
    logic m_cond = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    scalar_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .res_out(res_out),
        .cond_out(cond_out), .res_valid(res_valid), .bad_op(bad_op)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected behaviour derived from the requirements
    function automatic void model(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] r, output logic bad);
        longint s;
        logic [63:0] v;
        logic [31:0] t;
        bad = 1'b0;
        r   = '0;
        if (op == 5'd2) begin
            s = longint'($signed(a[31:0])) + longint'($signed(b[31:0]));
            r = {32'b0, s[31:0]};
            m_cond = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else if (op == 5'd6 || op == 5'd8) begin
            m_cond = (op == 5'd6) ? ($signed(a[31:0]) < $signed(b[31:0]))
                                  : ($signed(a[31:0]) > $signed(b[31:0]));
            r = {32'b0, m_cond ? a[31:0] : b[31:0]};
        end else if (op == 5'd7 || op == 5'd9) begin
            m_cond = (op == 5'd7) ? (a[31:0] < b[31:0]) : (a[31:0] > b[31:0]);
            r = {32'b0, m_cond ? a[31:0] : b[31:0]};
        end else if (op >= 5'd14) begin
            case (op[4:1])
                4'd7:  v = a & b;
                4'd8:  v = a | b;
                4'd9:  v = a ^ b;
                4'd10: v = a & ~b;
                4'd11: v = a | ~b;
                4'd12: v = ~(a & b);
                4'd13: v = ~(a | b);
                4'd14: v = ~(a ^ b);
                default: begin
                    t = a[31:0] << b[4:0];
                    v = op[0] ? (a << b[5:0]) : {32'b0, t};
                end
            endcase
            r = op[0] ? v : {32'b0, v[31:0]};
            m_cond = (r != 0);
        end else begin
            bad = 1'b1;
        end
    endfunction

    task automatic issue(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        opcode = op; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] er;
        logic eb;
        model(op, a, b, er, eb);
        issue(op, a, b);
        check({req, " result"}, res_out, er);
        check({req, " cond"}, {63'b0, cond_out}, {63'b0, m_cond});
        check({req, " valid R1"}, {63'b0, res_valid}, 64'd1);
        check({req, " bad_op"}, {63'b0, bad_op}, {63'b0, eb});
    endtask

    task automatic t_reset;
        check("R2 valid", {63'b0, res_valid}, 64'd0);
        check("R2 cond", {63'b0, cond_out}, 64'd0);
        check("R2 bad", {63'b0, bad_op}, 64'd0);
        check("R2 result", res_out, 64'd0);
    endtask

    task automatic t_logic;
        for (int op = 14; op <= 29; op++) begin
            run_op("R3", 5'(op), 64'hF0F0_1234_FF00_A5A5, 64'h0FF0_4321_0F0F_5AA5);
            run_op("R3", 5'(op), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_0000);
        end
    endtask

    task automatic t_zero_flag;
        run_op("R4", 5'd14, 64'h0000_00FF_0000_00F0, 64'h0000_FF00_0000_0F00);
        check("R4 zero and", res_out, 64'd0);
        check("R4 zero flag", {63'b0, cond_out}, 64'd0);
        // 32-bit form ignores a nonzero upper half
        run_op("R4", 5'd18, 64'hABCD_0000_1111_0000, 64'h0000_0000_1111_0000);
        check("R4 narrow xor flag", {63'b0, cond_out}, 64'd0);
    endtask

    task automatic t_narrow;
        run_op("R5", 5'd16, 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_0000_0002);
        check("R5 upper zero", res_out, 64'h0000_0000_0000_0003);
        run_op("R5", 5'd2, 64'hFFFF_0000_0000_0005, 64'h1234_0000_0000_0007);
        check("R5 add upper", res_out, 64'd12);
    endtask

    task automatic t_shift;
        run_op("R6", 5'd30, 64'h0000_0000_0000_0003, 64'd33);
        check("R6 narrow count masked", res_out, 64'd6);
        run_op("R6", 5'd30, 64'h0000_0000_8000_0000, 64'd1);
        check("R6 narrow drop", res_out, 64'd0);
        check("R6 narrow drop flag", {63'b0, cond_out}, 64'd0);
        run_op("R6", 5'd31, 64'h0000_0000_8000_0000, 64'd65);
        check("R6 wide count masked", res_out, 64'h0000_0001_0000_0000);
        run_op("R6", 5'd31, 64'h0000_0000_0000_00AB, 64'd32);
        check("R6 wide by 32", res_out, 64'h0000_00AB_0000_0000);
    endtask

    task automatic t_minmax;
        run_op("R7", 5'd6, 64'hFFFF_FFFF, 64'd1);
        check("R7 smin", res_out, 64'hFFFF_FFFF);
        check("R7 smin flag", {63'b0, cond_out}, 64'd1);
        run_op("R7", 5'd7, 64'hFFFF_FFFF, 64'd1);
        check("R7 umin", res_out, 64'd1);
        check("R7 umin flag", {63'b0, cond_out}, 64'd0);
        run_op("R7", 5'd8, 64'hFFFF_FFFF, 64'd1);
        check("R7 smax", res_out, 64'd1);
        run_op("R7", 5'd9, 64'hFFFF_FFFF, 64'd1);
        check("R7 umax", res_out, 64'hFFFF_FFFF);
        run_op("R7", 5'd9, 64'd5, 64'd5);
        check("R7 equal flag", {63'b0, cond_out}, 64'd0);
    endtask

    task automatic t_add;
        run_op("R8", 5'd2, 64'h7FFF_FFFF, 64'd1);
        check("R8 pos ovf", {63'b0, cond_out}, 64'd1);
        run_op("R8", 5'd2, 64'hFFFF_FFFF, 64'd1);
        check("R8 carry only", {63'b0, cond_out}, 64'd0);
        run_op("R8", 5'd2, 64'h8000_0000, 64'h8000_0000);
        check("R8 neg ovf", {63'b0, cond_out}, 64'd1);
        check("R8 neg ovf sum", res_out, 64'd0);
        run_op("R8", 5'd2, 64'h8000_0000, 64'hFFFF_FFFF_7FFF_FFFF);
        check("R8 edge min", {63'b0, cond_out}, 64'd0);
    endtask

    task automatic t_illegal;
        run_op("R9 setup", 5'd2, 64'h7FFF_FFFF, 64'd1);
        run_op("R9", 5'd3, 64'h1234, 64'h5678);
        check("R9 keep one", {63'b0, cond_out}, 64'd1);
        check("R9 zero", res_out, 64'd0);
        check("R9 flag", {63'b0, bad_op}, 64'd1);
        run_op("R9 setup", 5'd14, 64'd0, 64'd0);
        run_op("R9", 5'd0, 64'hFFFF, 64'hFFFF);
        check("R9 keep zero", {63'b0, cond_out}, 64'd0);
    endtask

    task automatic t_idle;
        run_op("R10 setup", 5'd17, 64'h55, 64'h0);
        repeat (3) @(negedge clk);
        opcode = 5'd14; src_a = '0; src_b = '0;
        repeat (2) @(negedge clk);
        check("R10 valid low", {63'b0, res_valid}, 64'd0);
        check("R10 result held", res_out, 64'h55);
        check("R10 cond held", {63'b0, cond_out}, 64'd1);
        check("R10 bad low", {63'b0, bad_op}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_logic;
        t_zero_flag;
        t_narrow;
        t_shift;
        t_minmax;
        t_add;
        t_illegal;
        t_idle;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule